// File: doc/BRIEF.md
# Four-Layer Alpha Blend Cascade

This block composites up to four pixel streams on top of an opaque background colour, one output pixel per accepted input beat. It is built as a chain of blend stages. The first stage blends layer 0 onto the background. Each later stage blends the next layer onto the result of the stage before it. Layer 3 therefore ends up on top. For each layer, software chooses whether it takes part and whether its colour bytes are already multiplied by its alpha.

A pixel is 32 bits: an alpha byte in the top lane and three colour bytes below it. The colour bytes are mixed lane by lane, whatever colour model they carry, and no lane is ever moved or converted. A beat is taken from all enabled source ports together, and only when every one of them offers data. A single ready signal at the output holds the whole chain. The layer flags and the background colour are captured on a frame-start strobe, so one frame is never composed with two different settings.

Top module: `alpha_layer_mixer`

## Requirements
- R1: For an enabled straight-alpha layer with alpha a, each colour lane becomes round(D*(255-a)/255) + round(S*a/255), where D is the destination lane and S is the source lane.
- R2: For an enabled premultiplied layer, each colour lane becomes round(D*(255-a)/255) + S.
- R3: For every enabled layer, in either mode, the alpha lane becomes round(Da*(255-a)/255) + a.
- R4: Stage 0 takes as its destination the captured 24-bit background in bits [23:0], with its alpha lane forced to 0xFF. As a result, every output pixel has alpha 0xFF.
- R5: A disabled layer leaves the destination unchanged. Its valid and data inputs have no effect, and its ready output stays 0.
- R6: Layer i is carried on src_pixel[32*i+31:32*i] and is blended by stage i. Stages run in increasing index order, so a higher layer covers a lower one.
- R7: Bits [31:24] hold alpha. Bits [23:16], [15:8] and [7:0] are three independent colour lanes, and each keeps its position from input to output.
- R8: Every division by 255 rounds to the nearest integer. Every lane sum that exceeds 255 saturates to 255.
- R9: The pixel of a beat accepted on clock edge k is presented on out_pixel, with out_valid high, after edge k+3 when no stall occurs. Beats leave in the order they were accepted, and none is lost.
- R10: While out_valid is 1 and out_ready is 0, out_pixel and out_valid hold their values and no source beat is accepted.
- R11: layer_en, layer_premul and bg_color are captured only on an edge where frame_start is 1. The new settings apply to beats accepted on later edges. Changes to these inputs at any other time have no effect.
- R12: A beat is accepted only when every enabled layer has src_valid at 1 and the output can advance, that is, out_ready is 1 or out_valid is 0. On that edge, src_ready is 1 for exactly the enabled layers. When no layer is enabled, a background-only beat is accepted on every edge where the output can advance.
- R13: During reset, out_valid and src_ready are 0. After reset, all layers are disabled and the captured background is 0x000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Strobe that captures the layer flags and the background colour |
| bg_color | input | 24 | Background colour lanes |
| layer_en | input | 4 | Per-layer enable |
| layer_premul | input | 4 | Per-layer premultiplied-alpha flag |
| src_valid | input | 4 | Per-layer source valid |
| src_ready | output | 4 | Per-layer source ready |
| src_pixel | input | 128 | Four source pixels, layer i in bits [32*i+31:32*i] |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Output pixel ready |
| out_pixel | output | 32 | Composited pixel |

## Verification
The hardest case to reach is a settings change that lands while beats of the previous frame are still inside the stages, combined with an output stall. It matters most when the old frame had no layers enabled, because then the block keeps accepting background beats up to the very edge of the frame-start strobe. The bench sweeps all 256 combinations of enable and premultiplied flags, one frame each. It strobes frame_start straight after the last beat of the previous frame, holds out_ready low on a fixed cadence, and scrambles the flag and background inputs in the middle of each frame. A scoreboard built from the blend formulas then has to match every pixel in order.

// File: rtl/amix_pkg.sv
`timescale 1ns/1ps
package amix_pkg;

   // Role of one byte lane inside a pixel
   typedef enum logic {
      CH_COLOUR = 1'b0,
      CH_ALPHA  = 1'b1
   } amix_ch_kind_e;

   // Number of byte lanes per pixel: alpha plus three colour lanes
   localparam int AMIX_LANES = 4;

endpackage

// File: rtl/amix_chan.sv
`timescale 1ns/1ps
// One lane of one blend stage: dst*(max-a)/max + (premul ? src : src*a/max), saturated
module amix_chan #(
   parameter int CH_W = 8
) (
   input  logic [CH_W-1:0] dst_v,
   input  logic [CH_W-1:0] src_v,
   input  logic [CH_W-1:0] src_a,
   input  logic            premul,
   output logic [CH_W-1:0] res_v
);
   localparam int PW = 2 * CH_W;
   localparam logic [PW:0] HALF = {{PW{1'b0}}, 1'b1} << (CH_W - 1);

   // Rounded division by (2^CH_W - 1) using a shift-and-add correction
   function automatic logic [CH_W-1:0] div_full(input logic [PW-1:0] p);
      logic [PW:0] t;
      t = {1'b0, p} + HALF;
      return CH_W'((t + (t >> CH_W)) >> CH_W);
   endfunction

   logic [CH_W-1:0] inv_a;
   logic [PW-1:0]   keep_prod;
   logic [PW-1:0]   take_prod;
   logic [CH_W-1:0] keep_term;
   logic [CH_W-1:0] add_term;
   logic [CH_W:0]   sum;

   assign inv_a     = ~src_a;
   assign keep_prod = {{CH_W{1'b0}}, dst_v} * {{CH_W{1'b0}}, inv_a};
   assign take_prod = {{CH_W{1'b0}}, src_v} * {{CH_W{1'b0}}, src_a};
   assign keep_term = div_full(keep_prod);
   assign add_term  = premul ? src_v : div_full(take_prod);
   assign sum       = {1'b0, keep_term} + {1'b0, add_term};
   assign res_v     = sum[CH_W] ? {CH_W{1'b1}} : sum[CH_W-1:0];

endmodule

// File: rtl/amix_blend.sv
`timescale 1ns/1ps
// Combinational blend of one source pixel onto a destination pixel
module amix_blend
   import amix_pkg::*;
#(
   parameter int CH_W = 8
) (
   input  logic [AMIX_LANES*CH_W-1:0] dst_pix,
   input  logic [AMIX_LANES*CH_W-1:0] src_pix,
   input  logic                       en,
   input  logic                       premul,
   output logic [AMIX_LANES*CH_W-1:0] res_pix
);
   localparam int PIX_W = AMIX_LANES * CH_W;

   logic [CH_W-1:0]  src_a;
   logic [PIX_W-1:0] mixed;

   assign src_a = src_pix[PIX_W-1 -: CH_W];

   for (genvar ln = 0; ln < AMIX_LANES; ln++) begin : g_lane
      localparam amix_ch_kind_e KIND = (ln == AMIX_LANES - 1) ? CH_ALPHA : CH_COLOUR;
      if (KIND == CH_ALPHA) begin : g_alpha
         // alpha lane: Da*(1-a) + a, same datapath as premultiplied with S = a
         amix_chan #(.CH_W(CH_W)) u_chan (
            .dst_v (dst_pix[ln*CH_W +: CH_W]),
            .src_v (src_a),
            .src_a (src_a),
            .premul(1'b1),
            .res_v (mixed[ln*CH_W +: CH_W])
         );
      end else begin : g_colour
         amix_chan #(.CH_W(CH_W)) u_chan (
            .dst_v (dst_pix[ln*CH_W +: CH_W]),
            .src_v (src_pix[ln*CH_W +: CH_W]),
            .src_a (src_a),
            .premul(premul),
            .res_v (mixed[ln*CH_W +: CH_W])
         );
      end
   end

   assign res_pix = en ? mixed : dst_pix;

endmodule

// File: rtl/amix_stage.sv
`timescale 1ns/1ps
// One pipeline stage: blend plus output register
module amix_stage
   import amix_pkg::*;
#(
   parameter int CH_W = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       adv,
   input  logic                       in_vld,
   input  logic [AMIX_LANES*CH_W-1:0] dst_pix,
   input  logic [AMIX_LANES*CH_W-1:0] src_pix,
   input  logic                       en,
   input  logic                       premul,
   output logic                       vld_q,
   output logic [AMIX_LANES*CH_W-1:0] pix_q
);
   localparam int PIX_W = AMIX_LANES * CH_W;

   logic [PIX_W-1:0] res_pix;
   logic [CH_W-1:0]  src_a;

   assign src_a = src_pix[PIX_W-1 -: CH_W];

   amix_blend #(.CH_W(CH_W)) u_blend (
      .dst_pix(dst_pix),
      .src_pix(src_pix),
      .en     (en),
      .premul (premul),
      .res_pix(res_pix)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         pix_q <= '0;
      end else if (adv) begin
         vld_q <= in_vld;
         if (in_vld) pix_q <= res_pix;
      end
   end

   // R5
   bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && in_vld && !en) |=> (pix_q == $past(dst_pix)));

   // R1
   clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && in_vld && en && !premul && src_a == '0) |=> (pix_q == $past(dst_pix)));

   // R2
   opaque_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && in_vld && en && src_a == '1) |=> (pix_q == $past(src_pix)));

   // R3
   alpha_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && in_vld && en) |=> (pix_q[PIX_W-1 -: CH_W] >= $past(src_a)));

endmodule

// File: rtl/amix_intake.sv
`timescale 1ns/1ps
// Frame settings capture and lockstep join of the enabled source ports
module amix_intake #(
   parameter int NUM_LAYERS = 4,
   parameter int COL_W      = 24
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  frame_start,
   input  logic [COL_W-1:0]      bg_color,
   input  logic [NUM_LAYERS-1:0] layer_en,
   input  logic [NUM_LAYERS-1:0] layer_premul,
   input  logic [NUM_LAYERS-1:0] src_valid,
   input  logic                  adv,
   output logic [NUM_LAYERS-1:0] cfg_en,
   output logic [NUM_LAYERS-1:0] cfg_pm,
   output logic [COL_W-1:0]      bg_q,
   output logic                  accept,
   output logic [NUM_LAYERS-1:0] src_ready
);
   logic join_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_en <= '0;
         cfg_pm <= '0;
         bg_q   <= '0;
      end else if (frame_start) begin
         cfg_en <= layer_en;
         cfg_pm <= layer_premul;
         bg_q   <= bg_color;
      end
   end

   assign join_ok   = &(src_valid | ~cfg_en);
   assign accept    = adv && join_ok;
   assign src_ready = accept ? cfg_en : '0;

   // R11
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> ($stable(cfg_en) && $stable(cfg_pm) && $stable(bg_q)));

   // R12
   join_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> ((src_valid & cfg_en) == cfg_en));

endmodule

// File: rtl/alpha_layer_mixer.sv
`timescale 1ns/1ps
module alpha_layer_mixer
   import amix_pkg::*;
#(
   parameter int NUM_LAYERS = 4,
   parameter int CH_W       = 8
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   frame_start,
   input  logic [(AMIX_LANES-1)*CH_W-1:0]         bg_color,
   input  logic [NUM_LAYERS-1:0]                  layer_en,
   input  logic [NUM_LAYERS-1:0]                  layer_premul,
   input  logic [NUM_LAYERS-1:0]                  src_valid,
   output logic [NUM_LAYERS-1:0]                  src_ready,
   input  logic [NUM_LAYERS*AMIX_LANES*CH_W-1:0]  src_pixel,
   output logic                                   out_valid,
   input  logic                                   out_ready,
   output logic [AMIX_LANES*CH_W-1:0]             out_pixel
);
   localparam int PIX_W = AMIX_LANES * CH_W;
   localparam int COL_W = (AMIX_LANES - 1) * CH_W;

   if (NUM_LAYERS < 1 || NUM_LAYERS > 8) begin : g_bad_layers
      $error("alpha_layer_mixer: NUM_LAYERS must be within 1..8");
   end
   if (CH_W < 2 || CH_W > 12) begin : g_bad_width
      $error("alpha_layer_mixer: CH_W must be within 2..12");
   end

   logic                        adv;
   logic                        accept;
   logic [NUM_LAYERS-1:0]       cfg_en;
   logic [NUM_LAYERS-1:0]       cfg_pm;
   logic [COL_W-1:0]            bg_q;
   logic [NUM_LAYERS-1:0]       stg_vld;
   logic [NUM_LAYERS*PIX_W-1:0] stg_pix;

   assign adv = out_ready || !out_valid;

   amix_intake #(.NUM_LAYERS(NUM_LAYERS), .COL_W(COL_W)) u_intake (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (frame_start),
      .bg_color    (bg_color),
      .layer_en    (layer_en),
      .layer_premul(layer_premul),
      .src_valid   (src_valid),
      .adv         (adv),
      .cfg_en      (cfg_en),
      .cfg_pm      (cfg_pm),
      .bg_q        (bg_q),
      .accept      (accept),
      .src_ready   (src_ready)
   );

   // Stage s owns a lane register holding the pixels and flags of layers s..N-1,
   // each stage dropping the lowest layer it has consumed.
   for (genvar s = 0; s < NUM_LAYERS; s++) begin : g_lane
      localparam int LN = NUM_LAYERS - s;
      localparam int LW = LN * PIX_W;

      logic [LW-1:0]    lane_pix;
      logic [LN-1:0]    lane_en;
      logic [LN-1:0]    lane_pm;
      logic [PIX_W-1:0] dst_pix;
      logic             in_vld;

      if (s == 0) begin : g_head
         assign lane_pix = src_pixel;
         assign lane_en  = cfg_en;
         assign lane_pm  = cfg_pm;
         assign dst_pix  = {{CH_W{1'b1}}, bg_q};
         assign in_vld   = accept;
      end else begin : g_tail
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lane_pix <= '0;
               lane_en  <= '0;
               lane_pm  <= '0;
            end else if (adv) begin
               lane_pix <= g_lane[s-1].lane_pix[LW+PIX_W-1:PIX_W];
               lane_en  <= g_lane[s-1].lane_en[LN:1];
               lane_pm  <= g_lane[s-1].lane_pm[LN:1];
            end
         end
         assign dst_pix = stg_pix[(s-1)*PIX_W +: PIX_W];
         assign in_vld  = stg_vld[s-1];

         // R9
         chain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (stg_vld[s-1] && adv) |=> stg_vld[s]);
      end

      amix_stage #(.CH_W(CH_W)) u_stage (
         .clk    (clk),
         .rst_n  (rst_n),
         .adv    (adv),
         .in_vld (in_vld),
         .dst_pix(dst_pix),
         .src_pix(lane_pix[PIX_W-1:0]),
         .en     (lane_en[0]),
         .premul (lane_pm[0]),
         .vld_q  (stg_vld[s]),
         .pix_q  (stg_pix[s*PIX_W +: PIX_W])
      );
   end

   assign out_valid = stg_vld[NUM_LAYERS-1];
   assign out_pixel = stg_pix[(NUM_LAYERS-1)*PIX_W +: PIX_W];

   // R4
   opaque_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_pixel[PIX_W-1 -: CH_W] == {CH_W{1'b1}}));

   // R10
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_pixel)));

   // R10
   stall_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> (src_ready == '0));

endmodule

// File: tb/alpha_layer_mixer_bench.sv
`timescale 1ns/1ps
module alpha_layer_mixer_bench;
   localparam int N = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         frame_start = 1'b0;
   logic [23:0]  bg_color = '0;
   logic [3:0]   layer_en = '0;
   logic [3:0]   layer_premul = '0;
   logic [3:0]   src_valid = '0;
   logic [3:0]   src_ready;
   logic [127:0] src_pixel = '0;
   logic         out_valid;
   logic         out_ready = 1'b1;
   logic [31:0]  out_pixel;

   always #2.5 clk = ~clk;

   alpha_layer_mixer u_alpha_layer_mixer (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .bg_color(bg_color),
      .layer_en(layer_en), .layer_premul(layer_premul), .src_valid(src_valid),
      .src_ready(src_ready), .src_pixel(src_pixel), .out_valid(out_valid),
      .out_ready(out_ready), .out_pixel(out_pixel)
   );

   int          checks = 0;
   int          fails = 0;
   bit          done = 1'b0;
   bit          acc_seen = 1'b0;
   bit          force_ready = 1'b1;
   int          cyc_d = 0;
   string       cur_tag = "R13 R4 reset background";
   logic [3:0]  m_en = '0;
   logic [3:0]  m_pm = '0;
   logic [23:0] m_bg = '0;
   logic [31:0] exp_q[$];
   string       tag_q[$];
   bit          prev_stall = 1'b0;
   logic [31:0] prev_pix = '0;

   function automatic int dv(int x);
      return (x + 127) / 255;
   endfunction

   function automatic int mix_lane(int d, int s, int a, bit pm);
      int t;
      t = dv(d * (255 - a)) + (pm ? s : dv(s * a));
      return (t > 255) ? 255 : t;
   endfunction

   function automatic logic [31:0] blend_px(logic [31:0] d, logic [31:0] s, bit pm);
      logic [31:0] r;
      int a;
      a = int'(s[31:24]);
      r[31:24] = 8'(mix_lane(int'(d[31:24]), a, a, 1'b1));
      for (int k = 0; k < 3; k++)
         r[k*8 +: 8] = 8'(mix_lane(int'(d[k*8 +: 8]), int'(s[k*8 +: 8]), a, pm));
      return r;
   endfunction

   function automatic logic [31:0] model_px(logic [127:0] px);
      logic [31:0] d;
      d = {8'hFF, m_bg};
      for (int l = 0; l < N; l++)
         if (m_en[l]) d = blend_px(d, px[l*32 +: 32], m_pm[l]);
      return d;
   endfunction

   function automatic logic [31:0] gen_px(int c, int b, int l);
      logic [31:0] p;
      int a;
      if (b == 0) a = 0;
      else if (b == 1) a = 255;
      else a = (c * 13 + b * 37 + l * 71) % 256;
      p[31:24] = 8'(a);
      for (int k = 0; k < 3; k++) p[k*8 +: 8] = 8'((c * 29 + b * 53 + l * 97 + k * 11) % 256);
      return p;
   endfunction

   task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   // Monitor: samples 0.5 ns before each rising edge
   always @(negedge clk) begin
      #2;
      if (!rst_n) begin
         check(!out_valid && src_ready == 4'b0, "R13 reset outputs", {27'b0, src_ready, out_valid}, 32'h0);
         prev_stall = 1'b0;
         acc_seen = 1'b0;
      end else begin
         bit adv, acc;
         logic [3:0] exp_rdy;
         adv = out_ready || !out_valid;
         acc = adv && (&(src_valid | ~m_en));
         exp_rdy = acc ? m_en : 4'b0;
         check(src_ready == exp_rdy, "R12 R5 ready", {28'b0, src_ready}, {28'b0, exp_rdy});
         if (prev_stall)
            check(out_valid && out_pixel == prev_pix, "R10 stall hold", out_pixel, prev_pix);
         prev_stall = out_valid && !out_ready;
         prev_pix = out_pixel;
         if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R9 unexpected output", out_pixel, 32'h0);
            end else begin
               logic [31:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(out_pixel == e, t, out_pixel, e);
            end
         end
         if (acc) begin
            exp_q.push_back(model_px(src_pixel));
            tag_q.push_back(cur_tag);
         end
         if (frame_start) begin
            m_en = layer_en;
            m_pm = layer_premul;
            m_bg = bg_color;
         end
         acc_seen = acc;
      end
   end

   task automatic tick();
      @(negedge clk);
      cyc_d++;
      out_ready = force_ready ? 1'b1 : ((cyc_d % 5) != 3);
   endtask

   task automatic send_beat(logic [127:0] px, logic [3:0] first_valid);
      src_pixel = px;
      src_valid = first_valid;
      forever begin
         tick();
         if (acc_seen) break;
         src_valid = 4'hF;
      end
      src_valid = 4'h0;
   endtask

   // R11: settings captured on the strobe, then the inputs are scrambled
   task automatic new_frame(logic [3:0] en, logic [3:0] pm, logic [23:0] bg);
      frame_start = 1'b1;
      layer_en = en;
      layer_premul = pm;
      bg_color = bg;
      src_valid = 4'h0;
      tick();
      frame_start = 1'b0;
      layer_en = ~en;
      layer_premul = ~pm;
      bg_color = ~bg;
   endtask

   initial begin
      #1000000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int n;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      // R13 R4: background-only beats flow with the reset settings
      repeat (8) tick();

      // R9 latency of a lone beat
      cur_tag = "R9 latency pixel";
      new_frame(4'b0001, 4'b0000, 24'h102030);
      repeat (6) tick();
      src_pixel = {96'h0, 32'h8040C000};
      src_valid = 4'b0001;
      n = 0;
      forever begin
         tick();
         n++;
         src_valid = 4'b0;
         if (out_valid || n > 10) break;
      end
      check(n == 4, "R9 latency", 32'(n), 32'd4);
      repeat (4) tick();

      // R8 premultiplied saturation on a white background
      cur_tag = "R8 R2 saturation";
      new_frame(4'b0001, 4'b0001, 24'hFFFFFF);
      send_beat({96'h0, 32'h00FFFFFF}, 4'b0001);
      send_beat({96'h0, 32'h40F0F0F0}, 4'b0001);
      // R1 R7 straight half alpha on black
      cur_tag = "R1 R7 straight half";
      new_frame(4'b0001, 4'b0000, 24'h000000);
      send_beat({96'h0, 32'h80FF0040}, 4'b0001);
      // R6 order: opaque layers, top one wins
      cur_tag = "R6 layer order";
      new_frame(4'b1111, 4'b0000, 24'h123456);
      send_beat({32'hFF0000AA, 32'hFF00BB00, 32'hFFCC0000, 32'hFF111111}, 4'b1111);

      // Sweep of all flag combinations with stalls
      force_ready = 1'b0;
      cur_tag = "R1 R2 R3 R4 R5 R6 R7 R10 R11 R12 sweep";
      for (int c = 0; c < 256; c++) begin
         new_frame(4'(c), 4'(c >> 4), 24'((c * 40503) & 24'hFFFFFF));
         for (int b = 0; b < 6; b++) begin
            logic [127:0] px;
            for (int l = 0; l < N; l++) px[l*32 +: 32] = gen_px(c, b, l);
            send_beat(px, 4'((b + c) % 16));
         end
      end

      force_ready = 1'b1;
      src_valid = 4'h0;
      repeat (12) tick();
      check(exp_q.size() == 0, "R9 beats lost", 32'(exp_q.size()), 32'd0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule